// File: doc/BRIEF.md
# Exception Entry and Instruction-State Controller

This block holds the control state that a 32-bit processor core changes when it takes an exception, when it returns from one, and when it switches between its 32-bit and 16-bit instruction encodings. It keeps an 8-bit current status word. The word holds the mode field, the instruction-state flag and two interrupt mask bits. For each of the five exception modes the block also keeps a saved status word and a link register. Every cycle the block resolves the exception request lines against a fixed priority and the current masks. It then performs at most one of three actions: an exception entry, an exception return or a branch-exchange.

When an action changes the program counter, the new counter value appears on `pc_o` and `pc_load` pulses for one cycle. The pipeline uses this pair to redirect fetch. Instruction decode, the general register file and memory stay outside the block. Asserting `rst_n` low is the reset exception. It has the highest priority and starts the core in supervisor mode, in the 32-bit state, at address zero.

Top module: `xcpt_entry_ctl`

## Requirements
- R1: While `rst_n` is low and after its release, `status_o` is 0xD3 and `pc_o` is 0 with `pc_load` low. 0xD3 decodes as supervisor mode 10011, state bit [5]=0, fast mask [6]=1 and normal mask [7]=1. Every saved status word resets to 0x10 (user mode, 32-bit state, masks clear) and every link register resets to 0.
- R2: Simultaneous requests are served in this order: data abort, fast interrupt, normal interrupt, prefetch abort, undefined, software interrupt. The vectors are 0x10, 0x1C, 0x18, 0x0C, 0x04 and 0x08 respectively.
- R3: On entry, bits [4:0] take the target mode and bit [5] clears. Bit [7] sets on every entry, and bit [6] sets only on a fast-interrupt entry (otherwise it keeps its value). The modes are: fast interrupt 10001, normal interrupt 10010, supervisor 10011 (software interrupt), abort 10111 (both aborts), undefined 11011, user 10000, system 11111.
- R4: On entry, the status word before the entry is stored as the saved status of the target mode, and `next_pc` is stored as that mode's link register.
- R5: A normal-interrupt request has no effect while bit [7] is set, and a fast-interrupt request has no effect while bit [6] is set. Lower-priority requests are then served as if the masked line were low.
- R6: A return request in an exception mode copies that mode's saved status into the status word and loads the PC with the link register minus an offset. The offset is 0 in every mode except abort. In abort mode it is 4, or 2 if the saved state bit [5] is 1.
- R7: A return request in user or system mode changes neither the status word nor the PC, and `pc_load` stays low.
- R8: A branch-exchange sets bit [5] to bit 0 of `bx_target` and loads the PC with `bx_target` with bit 0 cleared. The mode and mask bits are unchanged.
- R9: In one cycle an exception entry takes precedence over a return, and a return that is acted on takes precedence over a branch-exchange.
- R10: `pc_load` is high for exactly the one cycle after an entry, return or branch-exchange that was acted on, and `pc_o` holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, acts as the reset exception |
| req_dabt | input | 1 | Data abort request |
| req_fiq | input | 1 | Fast interrupt request |
| req_irq | input | 1 | Normal interrupt request |
| req_pabt | input | 1 | Prefetch abort request |
| req_und | input | 1 | Undefined instruction request |
| req_swi | input | 1 | Software interrupt request |
| next_pc | input | 32 | Address of the next instruction, stored as the link value |
| bx_req | input | 1 | Branch-exchange request |
| bx_target | input | 32 | Branch-exchange operand; bit 0 selects the state |
| ret_req | input | 1 | Exception-return request |
| pc_o | output | 32 | New program counter |
| pc_load | output | 1 | One-cycle strobe, `pc_o` carries a new value |
| status_o | output | 8 | Current status word: mode [4:0], state [5], fast mask [6], normal mask [7] |

## Verification
Directed sequences cover several cases. A return right after reset drops the core to user mode. A return issued in user mode must be ignored. A 16-bit-state prefetch abort and its return show that the abort offset depends on the saved state bit, which separates it from the 4-byte case. A burst of data abort, fast interrupt and normal interrupt requests in one cycle tells the priority order apart from the masking. A fast interrupt nested inside an abort handler shows that each mode has its own bank, because the abort link must come back intact after the nested fast interrupt returns. A random phase with a fixed seed then mixes sparse requests, returns and branch-exchanges, including same-cycle collisions that exercise the precedence rule. A bench model checks every cycle.

// File: rtl/xcpt_pkg.sv
package xcpt_pkg;

  localparam int PSR_W  = 8;
  localparam int NBANK  = 5;
  localparam int NREQ   = 6;
  localparam int BIDX_W = $clog2(NBANK);

  localparam int T_BIT = 5;
  localparam int F_BIT = 6;
  localparam int I_BIT = 7;

  localparam logic [4:0] M_USR = 5'b10000;
  localparam logic [4:0] M_FIQ = 5'b10001;
  localparam logic [4:0] M_IRQ = 5'b10010;
  localparam logic [4:0] M_SVC = 5'b10011;
  localparam logic [4:0] M_ABT = 5'b10111;
  localparam logic [4:0] M_UND = 5'b11011;
  localparam logic [4:0] M_SYS = 5'b11111;

  localparam logic [PSR_W-1:0] PSR_RST  = 8'hD3;
  localparam logic [PSR_W-1:0] SPSR_RST = 8'h10;

  // request vector positions, lowest index = highest priority
  localparam int RQ_DABT = 0;
  localparam int RQ_FIQ  = 1;
  localparam int RQ_IRQ  = 2;
  localparam int RQ_PABT = 3;
  localparam int RQ_UND  = 4;
  localparam int RQ_SWI  = 5;

  typedef enum logic [2:0] {
    XE_NONE, XE_DABT, XE_FIQ, XE_IRQ, XE_PABT, XE_UND, XE_SWI
  } xcpt_e;

  function automatic xcpt_e req_to_xcpt(input int idx);
    case (idx)
      RQ_DABT: return XE_DABT;
      RQ_FIQ:  return XE_FIQ;
      RQ_IRQ:  return XE_IRQ;
      RQ_PABT: return XE_PABT;
      RQ_UND:  return XE_UND;
      RQ_SWI:  return XE_SWI;
      default: return XE_NONE;
    endcase
  endfunction

  function automatic logic [4:0] xcpt_mode(input xcpt_e xe);
    case (xe)
      XE_DABT, XE_PABT: return M_ABT;
      XE_FIQ:           return M_FIQ;
      XE_IRQ:           return M_IRQ;
      XE_UND:           return M_UND;
      XE_SWI:           return M_SVC;
      default:          return M_SVC;
    endcase
  endfunction

  function automatic logic [7:0] xcpt_vector(input xcpt_e xe);
    case (xe)
      XE_UND:  return 8'h04;
      XE_SWI:  return 8'h08;
      XE_PABT: return 8'h0C;
      XE_DABT: return 8'h10;
      XE_IRQ:  return 8'h18;
      XE_FIQ:  return 8'h1C;
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic has_bank(input logic [4:0] m);
    return (m == M_FIQ) || (m == M_IRQ) || (m == M_SVC) ||
           (m == M_ABT) || (m == M_UND);
  endfunction

  function automatic logic [BIDX_W-1:0] bank_index(input logic [4:0] m);
    case (m)
      M_FIQ:   return BIDX_W'(0);
      M_IRQ:   return BIDX_W'(1);
      M_SVC:   return BIDX_W'(2);
      M_ABT:   return BIDX_W'(3);
      M_UND:   return BIDX_W'(4);
      default: return BIDX_W'(0);
    endcase
  endfunction

  function automatic logic [PSR_W-1:0] entry_status(input logic [PSR_W-1:0] old,
                                                    input xcpt_e xe);
    logic [PSR_W-1:0] w;
    w        = old;
    w[4:0]   = xcpt_mode(xe);
    w[T_BIT] = 1'b0;
    w[I_BIT] = 1'b1;
    if (xe == XE_FIQ) w[F_BIT] = 1'b1;
    return w;
  endfunction

  function automatic logic [2:0] ret_offset(input logic [4:0] m, input logic saved_t);
    if (m != M_ABT) return 3'd0;
    return saved_t ? 3'd2 : 3'd4;
  endfunction

endpackage

// File: rtl/xcpt_arbiter.sv
module xcpt_arbiter
  import xcpt_pkg::*;
(
  input  logic [NREQ-1:0] req,
  input  logic            mask_f,
  input  logic            mask_i,
  output logic            fire,
  output xcpt_e           xe
);
  logic [NREQ-1:0] eff;

  always_comb begin
    eff          = req;
    eff[RQ_FIQ]  = req[RQ_FIQ] & ~mask_f;
    eff[RQ_IRQ]  = req[RQ_IRQ] & ~mask_i;
    xe           = XE_NONE;
    for (int i = NREQ - 1; i >= 0; i--) begin
      if (eff[i]) xe = req_to_xcpt(i);
    end
    fire = |eff;
  end
endmodule

// File: rtl/xcpt_bank.sv
module xcpt_bank
  import xcpt_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] lr_in,
  input  logic [PSR_W-1:0]  psr_in,
  output logic [ADDR_W-1:0] lr_q,
  output logic [PSR_W-1:0]  psr_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lr_q  <= '0;
      psr_q <= SPSR_RST;
    end else if (wr_en) begin
      lr_q  <= lr_in;
      psr_q <= psr_in;
    end
  end
endmodule

// File: rtl/xcpt_entry_ctl.sv
module xcpt_entry_ctl
  import xcpt_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_dabt,
  input  logic              req_fiq,
  input  logic              req_irq,
  input  logic              req_pabt,
  input  logic              req_und,
  input  logic              req_swi,
  input  logic [ADDR_W-1:0] next_pc,
  input  logic              bx_req,
  input  logic [ADDR_W-1:0] bx_target,
  input  logic              ret_req,
  output logic [ADDR_W-1:0] pc_o,
  output logic              pc_load,
  output logic [PSR_W-1:0]  status_o
);
  logic [PSR_W-1:0]  psr_q, psr_d;
  logic [ADDR_W-1:0] pc_q, pc_d;
  logic              ld_q, ld_d;

  logic [NREQ-1:0]   req_vec;
  logic              ent_fire;
  xcpt_e             ent_xe;
  logic [4:0]        ent_mode;
  logic [ADDR_W-1:0] ent_vec;
  logic              ret_fire;
  logic              bx_fire;

  logic [NBANK-1:0][ADDR_W-1:0] lr_arr;
  logic [NBANK-1:0][PSR_W-1:0]  spsr_arr;
  logic [ADDR_W-1:0]            lr_sel;
  logic [PSR_W-1:0]             spsr_sel;

  always_comb begin
    req_vec          = '0;
    req_vec[RQ_DABT] = req_dabt;
    req_vec[RQ_FIQ]  = req_fiq;
    req_vec[RQ_IRQ]  = req_irq;
    req_vec[RQ_PABT] = req_pabt;
    req_vec[RQ_UND]  = req_und;
    req_vec[RQ_SWI]  = req_swi;
  end

  xcpt_arbiter u_arb (
    .req    (req_vec),
    .mask_f (psr_q[F_BIT]),
    .mask_i (psr_q[I_BIT]),
    .fire   (ent_fire),
    .xe     (ent_xe)
  );

  assign ent_mode = xcpt_mode(ent_xe);
  assign ent_vec  = ADDR_W'(xcpt_vector(ent_xe));

  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    xcpt_bank #(.ADDR_W(ADDR_W)) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_en  (ent_fire && (bank_index(ent_mode) == BIDX_W'(g))),
      .lr_in  (next_pc),
      .psr_in (psr_q),
      .lr_q   (lr_arr[g]),
      .psr_q  (spsr_arr[g])
    );
  end

  assign lr_sel   = lr_arr[bank_index(psr_q[4:0])];
  assign spsr_sel = spsr_arr[bank_index(psr_q[4:0])];

  assign ret_fire = ret_req && !ent_fire && has_bank(psr_q[4:0]);
  assign bx_fire  = bx_req && !ent_fire && !ret_fire;

  always_comb begin
    psr_d = psr_q;
    pc_d  = pc_q;
    ld_d  = 1'b0;
    if (ent_fire) begin
      psr_d = entry_status(psr_q, ent_xe);
      pc_d  = ent_vec;
      ld_d  = 1'b1;
    end else if (ret_fire) begin
      psr_d = spsr_sel;
      pc_d  = lr_sel - ADDR_W'(ret_offset(psr_q[4:0], spsr_sel[T_BIT]));
      ld_d  = 1'b1;
    end else if (bx_fire) begin
      psr_d[T_BIT] = bx_target[0];
      pc_d         = {bx_target[ADDR_W-1:1], 1'b0};
      ld_d         = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psr_q <= PSR_RST;
      pc_q  <= '0;
      ld_q  <= 1'b0;
    end else begin
      psr_q <= psr_d;
      pc_q  <= pc_d;
      ld_q  <= ld_d;
    end
  end

  assign pc_o     = pc_q;
  assign pc_load  = ld_q;
  assign status_o = psr_q;
endmodule

// File: rtl/xcpt_entry_chk.sv
module xcpt_entry_chk
  import xcpt_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ent_fire,
  input logic [4:0]        ent_mode,
  input logic [ADDR_W-1:0] ent_vec,
  input logic              ret_fire,
  input logic              bx_fire,
  input logic              bx_req,
  input logic              bx_bit0,
  input logic              ret_req,
  input logic [NREQ-1:0]   req_vec,
  input logic [ADDR_W-1:0] pc_o,
  input logic              pc_load,
  input logic [PSR_W-1:0]  status_o
);
  logic others_idle;
  assign others_idle = !req_vec[RQ_DABT] && !req_vec[RQ_FIQ] && !req_vec[RQ_PABT] &&
                       !req_vec[RQ_UND] && !req_vec[RQ_SWI];

  assert_entry_mode_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ent_fire |=> (status_o[4:0] == $past(ent_mode)) && !status_o[T_BIT] && status_o[I_BIT]);

  assert_fiq_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_fire && ent_mode == M_FIQ) |=> status_o[F_BIT]);

  assert_entry_vector_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ent_fire |=> pc_load && (pc_o == $past(ent_vec)));

  assert_irq_masked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o[I_BIT] && req_vec[RQ_IRQ] && others_idle && !bx_req && !ret_req) |=> !pc_load);

  assert_user_ret_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ret_req && !bx_req && others_idle && !req_vec[RQ_IRQ] &&
     (status_o[4:0] == M_USR || status_o[4:0] == M_SYS)) |=> ($stable(status_o) && !pc_load));

  assert_bx_state_R8: assert property (@(posedge clk) disable iff (!rst_n)
    bx_fire |=> (status_o[T_BIT] == $past(bx_bit0)) &&
                (status_o[4:0] == $past(status_o[4:0])) &&
                (status_o[7:6] == $past(status_o[7:6])));

  assert_precedence_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ent_fire && (ret_fire || bx_fire)) && !(ret_fire && bx_fire));

  assert_load_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(ent_fire || ret_fire || bx_fire) |=> !pc_load && $stable(pc_o));
endmodule

bind xcpt_entry_ctl xcpt_entry_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .ent_fire (ent_fire),
  .ent_mode (ent_mode),
  .ent_vec  (ent_vec),
  .ret_fire (ret_fire),
  .bx_fire  (bx_fire),
  .bx_req   (bx_req),
  .bx_bit0  (bx_target[0]),
  .ret_req  (ret_req),
  .req_vec  (req_vec),
  .pc_o     (pc_o),
  .pc_load  (pc_load),
  .status_o (status_o)
);

// File: tb/xcpt_entry_ctl_tb_top.sv
module xcpt_entry_ctl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_dabt = 0, req_fiq = 0, req_irq = 0, req_pabt = 0, req_und = 0, req_swi = 0;
  logic [31:0] next_pc = '0;
  logic        bx_req = 0;
  logic [31:0] bx_target = '0;
  logic        ret_req = 0;
  logic [31:0] pc_o;
  logic        pc_load;
  logic [7:0]  status_o;

  int n_cmp = 0;
  int n_bad = 0;

  // bench model state
  logic [7:0]  e_psr;
  logic [31:0] e_pc;
  logic        e_ld;
  logic [7:0]  e_spsr [5];
  logic [31:0] e_lr   [5];

  always #5 clk = ~clk;

  xcpt_entry_ctl dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_dabt(req_dabt), .req_fiq(req_fiq), .req_irq(req_irq),
    .req_pabt(req_pabt), .req_und(req_und), .req_swi(req_swi),
    .next_pc(next_pc), .bx_req(bx_req), .bx_target(bx_target),
    .ret_req(ret_req), .pc_o(pc_o), .pc_load(pc_load), .status_o(status_o)
  );

  function automatic int slot(input logic [4:0] m);
    case (m)
      5'b10011: return 0;
      5'b10001: return 1;
      5'b10010: return 2;
      5'b10111: return 3;
      5'b11011: return 4;
      default:  return -1;
    endcase
  endfunction

  task automatic check(input string tag);
    n_cmp++;
    if (status_o !== e_psr || pc_load !== e_ld || pc_o !== e_pc) begin
      n_bad++;
      $display("FAIL %s: status=%h load=%b pc=%h expected status=%h load=%b pc=%h",
               tag, status_o, pc_load, pc_o, e_psr, e_ld, e_pc);
    end
  endtask

  // r = {swi,und,pabt,irq,fiq,dabt}
  task automatic step(input string tag, input logic [5:0] r, input logic [31:0] np,
                      input logic bx, input logic [31:0] bt, input logic rt);
    string      t;
    logic       hit;
    logic [4:0] nm;
    logic [31:0] vec;
    int         k;
    @(negedge clk);
    {req_swi, req_und, req_pabt, req_irq, req_fiq, req_dabt} = r;
    next_pc = np; bx_req = bx; bx_target = bt; ret_req = rt;
    hit = 1'b1; nm = 5'b10011; vec = 0; t = "R10";
    if (r[0])                  begin nm = 5'b10111; vec = 32'h10; end
    else if (r[1] && !e_psr[6]) begin nm = 5'b10001; vec = 32'h1C; end
    else if (r[2] && !e_psr[7]) begin nm = 5'b10010; vec = 32'h18; end
    else if (r[3])             begin nm = 5'b10111; vec = 32'h0C; end
    else if (r[4])             begin nm = 5'b11011; vec = 32'h04; end
    else if (r[5])             begin nm = 5'b10011; vec = 32'h08; end
    else hit = 1'b0;
    e_ld = 1'b0;
    if (hit) begin
      k = slot(nm);
      e_spsr[k] = e_psr; e_lr[k] = np;
      e_psr = {1'b1, e_psr[6] | (nm == 5'b10001), 1'b0, nm};
      e_pc = vec; e_ld = 1'b1; t = "R3";
    end else if (rt && slot(e_psr[4:0]) >= 0) begin
      k = slot(e_psr[4:0]);
      e_pc = e_lr[k] - ((e_psr[4:0] == 5'b10111) ? (e_spsr[k][5] ? 32'd2 : 32'd4) : 32'd0);
      e_psr = e_spsr[k]; e_ld = 1'b1; t = "R6";
    end else if (bx) begin
      e_psr[5] = bt[0]; e_pc = {bt[31:1], 1'b0}; e_ld = 1'b1; t = "R8";
    end
    @(posedge clk); #1;
    check((tag != "") ? tag : t);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [5:0] r;
    e_psr = 8'hD3; e_pc = 0; e_ld = 0;
    for (int i = 0; i < 5; i++) begin e_spsr[i] = 8'h10; e_lr[i] = 0; end
    void'($urandom(32'd1357));
    repeat (3) @(posedge clk);
    #1; check("R1 reset held");
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1; check("R1 after release");

    step("R1 R6 return to reset-saved user word", 6'b0, 0, 0, 0, 1);
    step("R7 return in user ignored", 6'b0, 0, 0, 0, 1);
    step("R8 bx to 16-bit", 6'b0, 0, 1, 32'h1001, 0);
    step("R2 R3 prefetch abort from 16-bit", 6'b001000, 32'h1002, 0, 0, 0);
    step("R4 R6 abort return 16-bit offset", 6'b0, 0, 0, 0, 1);
    step("R8 bx to 32-bit", 6'b0, 0, 1, 32'h2000, 0);
    step("R2 dabt beats fiq and irq", 6'b000111, 32'h2004, 0, 0, 0);
    step("R5 irq masked in abort", 6'b000100, 32'h3000, 0, 0, 0);
    step("R3 nested fiq", 6'b000010, 32'h3008, 0, 0, 0);
    step("R5 fiq masked in fiq", 6'b000010, 32'h4000, 0, 0, 0);
    step("R4 R6 fiq return restores abort", 6'b0, 0, 0, 0, 1);
    step("R6 abort return 32-bit offset", 6'b0, 0, 0, 0, 1);
    step("R2 R9 fiq entry beats ret and bx", 6'b000010, 32'h5000, 1, 32'h7, 1);
    step("R9 ret beats bx", 6'b0, 0, 1, 32'h9, 1);
    step("R2 und over swi", 6'b110000, 32'h6000, 0, 0, 0);
    step("R6 und return", 6'b0, 0, 0, 0, 1);
    step("R2 swi", 6'b100000, 32'h6100, 0, 0, 0);
    step("R10 idle", 6'b0, 0, 0, 0, 0);

    for (int n = 0; n < 3000; n++) begin
      r = '0;
      for (int b = 0; b < 6; b++) r[b] = ($urandom % 12) == 0;
      step("", r, $urandom & 32'hFFFF_FFFE, ($urandom % 6) == 0, $urandom, ($urandom % 4) == 0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule